// File: doc/BRIEF.md
# Auto-Indexed Block Data Buffer

This block is a small byte store that sits between a host-side register interface and a serial-bus transaction engine. Software reaches every entry through one data register. Each read or write of that register touches the entry at a hidden software index and then moves the index forward by one. The index returns to zero whenever software reads the host control register. Software can therefore load or unload a whole block by issuing a run of consecutive accesses.

The transaction engine has its own sequential port. At the start of a transaction it gives a direction and a byte count. The buffer caps the count at the array depth and resets a private engine counter to entry zero. Each engine request then stores one received byte or fetches one byte for transmission, always in ascending order. Once the count is used up, the buffer refuses further engine requests. The array is a single-ported memory. When both sides request in the same cycle, the engine gets it and the software access is dropped and flagged as stalled.

Top module: `blkbuf_top`

## Requirements
- R1: After a synchronous reset, `sw_rvalid` and `eng_rvalid` are 0 and `eng_done` is 1. The software index is 0, and the engine limit and counter are both 0.
- R2: A granted write on the data register stores `sw_wdata` at the software index. A granted read returns the entry at the software index on `sw_rdata`, with `sw_rvalid` high in the next cycle. Each granted access advances the index by one.
- R3: A pulse on `ctrl_rd` sets the software index to 0 for the next cycle. A data access in the same cycle uses the index as it was before the clear.
- R4: The software index wraps from DEPTH-1 to 0.
- R5: `eng_start` resets the engine counter to 0, latches `eng_dir`, and latches the limit min(`eng_count`, DEPTH). An engine request in the start cycle is ignored.
- R6: With direction 1 (bus to array), each granted `eng_req` stores `eng_wdata` at the engine counter. With direction 0 (array to bus), each granted `eng_req` returns the entry on `eng_rdata`, with `eng_rvalid` high in the next cycle. In both directions the counter then increments, so entries are visited from 0 upward.
- R7: When `eng_req` is granted while a software access is requested, the engine access is performed. The software access does nothing: no write, no `sw_rvalid`, no index step. `sw_stall` is high in that cycle.
- R8: `eng_done` is high exactly when the engine counter equals the limit. Engine requests while done neither write nor raise `eng_rvalid`, and the counter never exceeds the limit.
- R9: The engine counter and the software index are independent. `ctrl_rd` does not move the engine counter, and `eng_start` or engine accesses do not move the software index.
- R10: When `sw_wr` and `sw_rd` are both high, only the write is performed. `sw_rvalid` stays low and the index steps once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Data register write strobe |
| sw_rd | input | 1 | Data register read strobe |
| sw_wdata | input | DW | Data register write value |
| ctrl_rd | input | 1 | Host control register read pulse (clears index) |
| sw_rdata | output | DW | Data register read value |
| sw_rvalid | output | 1 | sw_rdata valid (one cycle after read) |
| sw_stall | output | 1 | Software access dropped this cycle |
| eng_start | input | 1 | Transaction start pulse |
| eng_dir | input | 1 | 1 = bus to array, 0 = array to bus |
| eng_count | input | CNT_W | Byte count, capped at DEPTH |
| eng_req | input | 1 | Engine byte request |
| eng_wdata | input | DW | Byte received from the bus |
| eng_rdata | output | DW | Byte fetched for the bus |
| eng_rvalid | output | 1 | eng_rdata valid (one cycle after request) |
| eng_done | output | 1 | Engine counter has reached the limit |

## Verification
A wrong software index appears on the very next data read as a byte from a neighbouring entry. A missed clear or a missed wrap appears on the first read after `ctrl_rd`, or on the read that follows entry DEPTH-1. An engine counter that is wrong or unbounded appears one cycle after the faulty request, either as wrong fetched data or as an `eng_rvalid` beyond the limit. A stored byte that lands in the wrong place shows up when software later reads that entry back. A lost arbitration shows up as an entry overwritten by the software value, or as the next software read landing one entry too far.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;
  typedef enum logic {
    DIR_TO_BUS   = 1'b0,
    DIR_FROM_BUS = 1'b1
  } eng_dir_e;
endpackage

// File: rtl/blkbuf_ram.sv
module blkbuf_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, registered output
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/blkbuf_swptr.sv
module blkbuf_swptr #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (clr)  idx <= '0;
    else if (step) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> idx == '0); // R3
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr && step && idx == LAST) |=> idx == '0); // R4
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |=> $stable(idx)); // R7
endmodule

// File: rtl/blkbuf_engctr.sv
module blkbuf_engctr
  import blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             dir_in,
  input  logic [CNT_W-1:0] count,
  input  logic             req,
  output logic             grant,
  output logic             done,
  output eng_dir_e         dir,
  output logic [AW-1:0]    addr
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign done  = (cnt == lim);
  assign grant = req && !start && !done;
  assign addr  = cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= '0;
      dir <= DIR_TO_BUS;
    end else if (start) begin
      cnt <= '0;
      lim <= (count > DEPTH_C) ? CW'(DEPTH) : CW'(count);
      dir <= eng_dir_e'(dir_in);
    end else if (grant) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim); // R8
  AST_LIM_CAP: assert property (@(posedge clk) disable iff (rst)
    lim <= CW'(DEPTH)); // R5
  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt == '0); // R5
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(cnt)); // R8
endmodule

// File: rtl/blkbuf_arb.sv
module blkbuf_arb
  import blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_wr,
  input  logic          sw_rd,
  input  logic [DW-1:0] sw_wdata,
  input  logic [AW-1:0] sw_idx,
  input  logic          eng_grant,
  input  eng_dir_e      eng_dir,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_wdata,
  output logic          sw_grant,
  output logic          sw_stall,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          sw_rvalid,
  output logic          eng_rvalid
);
  logic sw_req;
  assign sw_req   = sw_wr || sw_rd;
  assign sw_grant = sw_req && !eng_grant;
  assign sw_stall = sw_req && eng_grant;

  always_comb begin
    if (eng_grant) begin
      ram_addr  = eng_addr;
      ram_we    = (eng_dir == DIR_FROM_BUS);
      ram_wdata = eng_wdata;
    end else begin
      ram_addr  = sw_idx;
      ram_we    = sw_grant && sw_wr;
      ram_wdata = sw_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_rvalid  <= 1'b0;
      eng_rvalid <= 1'b0;
    end else begin
      sw_rvalid  <= sw_grant && sw_rd && !sw_wr;
      eng_rvalid <= eng_grant && (eng_dir == DIR_TO_BUS);
    end
  end

  AST_RVALID_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    sw_rvalid |-> $past(sw_rd && !sw_wr)); // R10
  AST_STALL_NO_RVALID: assert property (@(posedge clk) disable iff (rst)
    sw_stall |=> !sw_rvalid); // R7
endmodule

// File: rtl/blkbuf_top.sv
module blkbuf_top
  import blkbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_wr,
  input  logic             sw_rd,
  input  logic [DW-1:0]    sw_wdata,
  input  logic             ctrl_rd,
  output logic [DW-1:0]    sw_rdata,
  output logic             sw_rvalid,
  output logic             sw_stall,
  input  logic             eng_start,
  input  logic             eng_dir,
  input  logic [CNT_W-1:0] eng_count,
  input  logic             eng_req,
  input  logic [DW-1:0]    eng_wdata,
  output logic [DW-1:0]    eng_rdata,
  output logic             eng_rvalid,
  output logic             eng_done
);
  localparam int AW = $clog2(DEPTH);

  logic          sw_grant, eng_grant, ram_we;
  logic [AW-1:0] sw_idx, eng_addr, ram_addr;
  logic [DW-1:0] ram_wdata, ram_q;
  eng_dir_e      dir_q;

  blkbuf_swptr #(.DEPTH(DEPTH)) u_swptr (
    .clk(clk), .rst(rst), .clr(ctrl_rd), .step(sw_grant), .idx(sw_idx)
  );

  blkbuf_engctr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_engctr (
    .clk(clk), .rst(rst), .start(eng_start), .dir_in(eng_dir),
    .count(eng_count), .req(eng_req), .grant(eng_grant),
    .done(eng_done), .dir(dir_q), .addr(eng_addr)
  );

  blkbuf_arb #(.DEPTH(DEPTH), .DW(DW)) u_arb (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_rd(sw_rd),
    .sw_wdata(sw_wdata), .sw_idx(sw_idx), .eng_grant(eng_grant),
    .eng_dir(dir_q), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .sw_grant(sw_grant), .sw_stall(sw_stall), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .sw_rvalid(sw_rvalid), .eng_rvalid(eng_rvalid)
  );

  blkbuf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_q)
  );

  assign sw_rdata  = ram_q;
  assign eng_rdata = ram_q;

  AST_ENG_RVALID_DIR: assert property (@(posedge clk) disable iff (rst)
    eng_rvalid |-> $past(eng_req && !eng_done)); // R8
  AST_START_HOLDS_IDX: assert property (@(posedge clk) disable iff (rst)
    (eng_start && !ctrl_rd && !sw_wr && !sw_rd) |=> $stable(sw_idx)); // R9
endmodule

// File: tb/tb_blkbuf_top.sv
module tb_blkbuf_top;
  localparam int DEPTH = 32;
  localparam int DW    = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic sw_wr = 0, sw_rd = 0, ctrl_rd = 0;
  logic [DW-1:0] sw_wdata = '0;
  logic [DW-1:0] sw_rdata;
  logic sw_rvalid, sw_stall;
  logic eng_start = 0, eng_dir = 0, eng_req = 0;
  logic [CNT_W-1:0] eng_count = '0;
  logic [DW-1:0] eng_wdata = '0;
  logic [DW-1:0] eng_rdata;
  logic eng_rvalid, eng_done;

  blkbuf_top #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_wdata(sw_wdata),
    .ctrl_rd(ctrl_rd), .sw_rdata(sw_rdata), .sw_rvalid(sw_rvalid),
    .sw_stall(sw_stall), .eng_start(eng_start), .eng_dir(eng_dir),
    .eng_count(eng_count), .eng_req(eng_req), .eng_wdata(eng_wdata),
    .eng_rdata(eng_rdata), .eng_rvalid(eng_rvalid), .eng_done(eng_done)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] model [DEPTH];
  int sidx = 0, ecnt = 0, elim = 0;
  bit edir = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sw_op(bit wr, bit rd, logic [DW-1:0] d, string tag);
    @(negedge clk); sw_wr = wr; sw_rd = rd; sw_wdata = d;
    @(negedge clk); sw_wr = 0; sw_rd = 0;
    if (wr) model[sidx] = d;
    if (rd && !wr)
      chk(sw_rvalid && sw_rdata == model[sidx], tag, {sw_rvalid, sw_rdata}, {1'b1, model[sidx]});
    else
      chk(!sw_rvalid, tag, sw_rvalid, 0);
    sidx = (sidx + 1) % DEPTH;
  endtask

  task automatic do_ctrl();
    @(negedge clk); ctrl_rd = 1;
    @(negedge clk); ctrl_rd = 0;
    sidx = 0;
  endtask

  task automatic eng_go(bit dir, int count);
    @(negedge clk); eng_start = 1; eng_dir = dir; eng_count = CNT_W'(count);
    @(negedge clk); eng_start = 0;
    ecnt = 0; elim = (count > DEPTH) ? DEPTH : count; edir = dir;
  endtask

  task automatic eng_op(logic [DW-1:0] d, string tag);
    @(negedge clk); eng_req = 1; eng_wdata = d;
    @(negedge clk); eng_req = 0;
    if (ecnt < elim) begin
      if (edir) begin
        model[ecnt] = d;
        chk(!eng_rvalid, tag, eng_rvalid, 0);
      end else begin
        chk(eng_rvalid && eng_rdata == model[ecnt], tag, {eng_rvalid, eng_rdata}, {1'b1, model[ecnt]});
      end
      ecnt++;
    end else begin
      chk(!eng_rvalid, {tag, " over limit"}, eng_rvalid, 0);
    end
    chk(eng_done == (ecnt == elim), {tag, " done"}, eng_done, (ecnt == elim));
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(!sw_rvalid && !eng_rvalid, "R1 rvalid idle", {sw_rvalid, eng_rvalid}, 0);
    chk(eng_done, "R1 done after reset", eng_done, 1);
    // R8 idle engine ignores requests
    ecnt = 0; elim = 0; edir = 0;
    eng_op(8'h11, "R8 idle request");

    // R2 fill all entries, R1 index at 0 after reset
    for (int i = 0; i < DEPTH; i++) sw_op(1, 0, DW'(i * 37 + 5), "R2 write");
    do_ctrl();
    for (int i = 0; i < DEPTH; i++) sw_op(0, 1, 8'h00, "R2 read back");
    // R4 wrap: index is back at 0
    sw_op(0, 1, 8'h00, "R4 wrap read");

    // R3 clear mid-stream, and same-cycle access uses old index
    do_ctrl();
    sw_op(0, 1, 8'h00, "R3 pre");
    sw_op(0, 1, 8'h00, "R3 pre");
    @(negedge clk); sw_rd = 1; ctrl_rd = 1;
    @(negedge clk); sw_rd = 0; ctrl_rd = 0;
    chk(sw_rvalid && sw_rdata == model[2], "R3 same-cycle old index", sw_rdata, model[2]);
    sidx = 0;
    sw_op(0, 1, 8'h00, "R3 after clear");

    // R10 simultaneous read and write
    sw_op(1, 1, 8'hC3, "R10 wr+rd no rvalid");
    do_ctrl();
    sw_op(0, 1, 8'h00, "R10 entry0");
    sw_op(0, 1, 8'h00, "R10 written entry1");

    // R5/R6/R8 fetch direction with count above depth (capped)
    eng_go(0, 40);
    for (int i = 0; i < 10; i++) eng_op(8'h00, "R6 fetch");
    do_ctrl(); // R9 control read does not disturb engine
    for (int i = 10; i < DEPTH + 2; i++) eng_op(8'h00, "R9 fetch after ctrl");

    // R9 engine start leaves software index alone
    do_ctrl();
    sw_op(0, 1, 8'h00, "R9 sw");
    sw_op(0, 1, 8'h00, "R9 sw");
    eng_go(1, 5);
    sw_op(0, 1, 8'h00, "R9 sw index kept");
    for (int i = 0; i < 7; i++) eng_op(DW'(8'hA0 + i), "R6 store");
    do_ctrl();
    for (int i = 0; i < 6; i++) sw_op(0, 1, 8'h00, "R6 store readback");

    // R5 zero count is done at once
    eng_go(0, 0);
    chk(eng_done, "R5 zero count done", eng_done, 1);

    // R7 collision: engine stores entry 0, software at index 2
    eng_go(1, 2);
    do_ctrl();
    sw_op(0, 1, 8'h00, "R7 pre");
    sw_op(0, 1, 8'h00, "R7 pre");
    @(negedge clk); sw_wr = 1; sw_wdata = 8'h55; eng_req = 1; eng_wdata = 8'h66;
    #1 chk(sw_stall, "R7 stall flag", sw_stall, 1);
    @(negedge clk); sw_wr = 0; eng_req = 0;
    chk(!sw_rvalid, "R7 no sw rvalid", sw_rvalid, 0);
    model[0] = 8'h66; ecnt = 1;
    sw_op(0, 1, 8'h00, "R7 index not stepped, entry untouched");
    @(negedge clk); sw_rd = 1;
    #1 chk(!sw_stall, "R7 no stall alone", sw_stall, 0);
    @(negedge clk); sw_rd = 0; sidx = (sidx + 1) % DEPTH;
    do_ctrl();
    sw_op(0, 1, 8'h00, "R7 engine byte landed");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule